// File: doc/BRIEF.md
# Hardware Counter CSR Unit

This block holds the three 64-bit counters of a hart (elapsed cycles, wall-clock time and retired instructions) together with two 32-bit counter-enable registers. One is owned by machine level and gates supervisor reads. The other is owned by supervisor level and gates user reads. Software reaches the counters through one CSR address bus and a write strobe. A per-cycle `tick` advances the cycle and time counters. A `retire` pulse advances the retired-instruction counter.

The block also answers one question for the CSR pipeline through a combinational flag: may the counter CSR on `csr_addr` be read at privilege `priv`? A software write to the retired-instruction counter is made by an instruction that itself retires. That instruction's own retire pulse must not add to the value software just wrote. The block keeps a pending-write flag for this, and the flag swallows exactly one later retire pulse.

Write addresses: 0xB00 cycle, 0xB01 time, 0xB02 retired instructions, 0x306 machine enable register, 0x106 supervisor enable register. Enable bit positions: bit 0 gates cycle, bit 1 gates time, bit 2 gates retired instructions. Privilege encoding: 0 user, 1 supervisor, 2 and 3 machine.

Top module: `hpc_csr_unit`

## Requirements
- R1: After reset, all three counters and both enable registers read zero, and the pending-write flag is clear.
- R2: The cycle counter adds one on each clock with `tick` high and holds when `tick` is low; it wraps from all-ones to zero.
- R3: A write to address 0xB00 loads `csr_wdata` into the cycle counter and takes priority over a `tick` in the same cycle.
- R4: The time counter adds one on each clock with `tick` high, and a write to 0xB01 loads it with priority over `tick`.
- R5: A write to 0x306 or 0x106 stores only bits 2..0 of `csr_wdata`; bits 31..3 of both enable registers always read zero.
- R6: At privilege 2 or 3, `access_ok` is 1 for addresses 0xC00, 0xC01 and 0xC02.
- R7: At privilege 1, `access_ok` for 0xC00/0xC01/0xC02 equals bit 0/1/2 of the machine enable register.
- R8: At privilege 0, `access_ok` for 0xC00/0xC01/0xC02 equals bit 0/1/2 of the supervisor enable register.
- R9: For addresses 0xC03 through 0xC1F (unsigned), `access_ok` is 0 at every privilege; every address outside 0xC00..0xC1F gives 1.
- R10: With no write pending, each clock with `retire` high adds one to the retired-instruction counter; without retire or write it holds.
- R11: A write to 0xB02 loads the counter and sets the pending flag. The next retire pulse, however late, is then consumed without an increment and clears the flag. Later pulses increment normally.
- R12: A write to 0xB02 in the same cycle as `retire` loads the written value with no increment and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address for the access check and for writes |
| priv | input | 2 | Current privilege (0 user, 1 supervisor, 2/3 machine) |
| csr_we | input | 1 | Write strobe for the CSR at `csr_addr` |
| csr_wdata | input | 64 | Write data |
| tick | input | 1 | Advances the cycle and time counters |
| retire | input | 1 | One instruction retired this cycle |
| cycle_q | output | 64 | Cycle counter |
| time_q | output | 64 | Time counter |
| instret_q | output | 64 | Retired-instruction counter |
| m_cnten_q | output | 32 | Machine-owned enable register |
| s_cnten_q | output | 32 | Supervisor-owned enable register |
| access_ok | output | 1 | Counter read permitted at `priv` |

## Verification
The hardest case to reach is the pending-write flag, which no port shows. It must be seen through the counter value alone, across separate retire pulses. The bench writes the counter and then leaves idle cycles before the first retire, which shows the flag survives. It then sends two retires and expects exactly one increment. A second scenario issues the write and a retire in the same cycle. Here the bench expects the written value to hold across one further retire before counting resumes.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int XLEN      = 64;
  localparam int ENW       = 32;
  localparam int IMPL_BITS = 3;   // cycle, time, instret enables
  localparam int AW        = 12;

  localparam logic [1:0] PRIV_USER = 2'd0;
  localparam logic [1:0] PRIV_SUP  = 2'd1;

  localparam logic [AW-1:0] A_WR_CYCLE   = 12'hB00;
  localparam logic [AW-1:0] A_WR_TIME    = 12'hB01;
  localparam logic [AW-1:0] A_WR_INSTRET = 12'hB02;
  localparam logic [AW-1:0] A_M_CNTEN    = 12'h306;
  localparam logic [AW-1:0] A_S_CNTEN    = 12'h106;

  localparam logic [AW-1:0] A_RD_FIRST   = 12'hC00;
  localparam logic [AW-1:0] A_RD_LAST    = 12'hC02;
  localparam logic [AW-1:0] A_HPM_FIRST  = 12'hC03;
  localparam logic [AW-1:0] A_HPM_LAST   = 12'hC1F;
endpackage

// File: rtl/hpc_counter.sv
module hpc_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + W'(1);
  end
endmodule

// File: rtl/hpc_instret.sv
module hpc_instret #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         retire,
  output logic [W-1:0] q
);
  logic pend_q;
  logic bump;

  // a pending write swallows the next retire pulse
  assign bump = retire && !pend_q && !wr;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (wr)     pend_q <= 1'b1;
    else if (retire) pend_q <= 1'b0;
  end

  hpc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(wr), .load_val(wdata), .inc(bump), .q(q)
  );
endmodule

// File: rtl/hpc_access.sv
module hpc_access
  import hpc_pkg::*;
(
  input  logic [AW-1:0]        addr,
  input  logic [1:0]           priv,
  input  logic [IMPL_BITS-1:0] m_en,
  input  logic [IMPL_BITS-1:0] s_en,
  output logic                 ok
);
  logic [1:0] idx;
  assign idx = addr[1:0];

  always_comb begin
    ok = 1'b1;
    if (addr >= A_HPM_FIRST && addr <= A_HPM_LAST) begin
      ok = 1'b0;
    end else if (addr >= A_RD_FIRST && addr <= A_RD_LAST) begin
      case (priv)
        PRIV_USER: ok = s_en[idx];
        PRIV_SUP:  ok = m_en[idx];
        default:   ok = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/hpc_csr_unit.sv
module hpc_csr_unit
  import hpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   csr_addr,
  input  logic [1:0]      priv,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            tick,
  input  logic            retire,
  output logic [XLEN-1:0] cycle_q,
  output logic [XLEN-1:0] time_q,
  output logic [XLEN-1:0] instret_q,
  output logic [ENW-1:0]  m_cnten_q,
  output logic [ENW-1:0]  s_cnten_q,
  output logic            access_ok
);
  localparam int NEN = 2;
  localparam logic [AW-1:0] EN_ADDR [NEN] = '{A_M_CNTEN, A_S_CNTEN};

  logic [IMPL_BITS-1:0] en_q [NEN];

  genvar g;
  generate
    for (g = 0; g < NEN; g++) begin : g_en
      always_ff @(posedge clk) begin
        if (!rst_n) en_q[g] <= '0;
        else if (csr_we && csr_addr == EN_ADDR[g])
          en_q[g] <= csr_wdata[IMPL_BITS-1:0];
      end
    end
  endgenerate

  assign m_cnten_q = {{(ENW-IMPL_BITS){1'b0}}, en_q[0]};
  assign s_cnten_q = {{(ENW-IMPL_BITS){1'b0}}, en_q[1]};

  hpc_counter #(.W(XLEN)) u_cycle (
    .clk(clk), .rst_n(rst_n),
    .load(csr_we && csr_addr == A_WR_CYCLE), .load_val(csr_wdata),
    .inc(tick), .q(cycle_q)
  );

  hpc_counter #(.W(XLEN)) u_time (
    .clk(clk), .rst_n(rst_n),
    .load(csr_we && csr_addr == A_WR_TIME), .load_val(csr_wdata),
    .inc(tick), .q(time_q)
  );

  hpc_instret #(.W(XLEN)) u_instret (
    .clk(clk), .rst_n(rst_n),
    .wr(csr_we && csr_addr == A_WR_INSTRET), .wdata(csr_wdata),
    .retire(retire), .q(instret_q)
  );

  hpc_access u_access (
    .addr(csr_addr), .priv(priv), .m_en(en_q[0]), .s_en(en_q[1]), .ok(access_ok)
  );
endmodule

// File: rtl/hpc_csr_unit_chk.sv
module hpc_csr_unit_chk
  import hpc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   csr_addr,
  input logic [1:0]      priv,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_wdata,
  input logic            tick,
  input logic            retire,
  input logic [XLEN-1:0] cycle_q,
  input logic [XLEN-1:0] time_q,
  input logic [XLEN-1:0] instret_q,
  input logic [ENW-1:0]  m_cnten_q,
  input logic [ENW-1:0]  s_cnten_q,
  input logic            access_ok
);
  // R2
  cycle_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(csr_we && csr_addr == A_WR_CYCLE)) |=> cycle_q == $past(cycle_q) + 64'd1);

  // R3
  cycle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == A_WR_CYCLE) |=> cycle_q == $past(csr_wdata));

  // R5
  en_hpm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> (m_cnten_q[ENW-1:IMPL_BITS] == '0 && s_cnten_q[ENW-1:IMPL_BITS] == '0));

  // R7
  sup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_SUP && csr_addr == A_RD_FIRST) |-> access_ok == m_cnten_q[0]);

  // R9
  hpm_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr >= A_HPM_FIRST && csr_addr <= A_HPM_LAST) |-> !access_ok);

  // R10
  instret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !(csr_we && csr_addr == A_WR_INSTRET)) |=> $stable(instret_q));

  // R12
  instret_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == A_WR_INSTRET) |=> instret_q == $past(csr_wdata));
endmodule

bind hpc_csr_unit hpc_csr_unit_chk u_chk (.*);

// File: tb/hpc_csr_unit_tb.sv
module hpc_csr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  priv = 2'd3;
  logic        csr_we = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic        tick = 1'b0;
  logic        retire = 1'b0;
  logic [63:0] cycle_q, time_q, instret_q;
  logic [31:0] m_cnten_q, s_cnten_q;
  logic        access_ok;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;   // 50 MHz

  hpc_csr_unit u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs already set at negedge, sample at next negedge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [63:0] d, input logic ret, input logic tk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1; retire = ret; tick = tk;
    step();
    csr_we = 1'b0; retire = 1'b0; tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick = 1'b1; retire = 1'b1;
    step(); step();
    tick = 1'b0; retire = 1'b0;
    rst_n = 1'b1;
    chk("R1 cycle", cycle_q, 64'd0);
    chk("R1 time", time_q, 64'd0);
    chk("R1 instret", instret_q, 64'd0);
    chk("R1 m_en", {32'd0, m_cnten_q}, 64'd0);
    chk("R1 s_en", {32'd0, s_cnten_q}, 64'd0);
    // R1: flag clear, so first retire counts
    retire = 1'b1; step(); retire = 1'b0;
    chk("R1 no pending flag", instret_q, 64'd1);
  endtask

  task automatic t_tick();
    logic [63:0] c0, t0;
    c0 = cycle_q; t0 = time_q;
    tick = 1'b1;
    for (int i = 0; i < 5; i++) step();
    tick = 1'b0;
    chk("R2 cycle +5", cycle_q, c0 + 64'd5);
    chk("R4 time +5", time_q, t0 + 64'd5);
    step(); step();
    chk("R2 cycle hold", cycle_q, c0 + 64'd5);
  endtask

  task automatic t_write_prio();
    csr_write(12'hB00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    chk("R3 cycle load beats tick", cycle_q, 64'hFFFF_FFFF_FFFF_FFFF);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R2 cycle wrap", cycle_q, 64'd0);
    csr_write(12'hB01, 64'h1234, 1'b0, 1'b1);
    chk("R4 time load beats tick", time_q, 64'h1234);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R4 time inc after load", time_q, 64'h1235);
  endtask

  task automatic t_enables();
    csr_write(12'h306, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    chk("R5 m_en masked", {32'd0, m_cnten_q}, 64'd7);
    csr_write(12'h106, 64'h0000_0000_FFFF_FFFA, 1'b0, 1'b0);
    chk("R5 s_en masked", {32'd0, s_cnten_q}, 64'd2);
    csr_write(12'h306, 64'd5, 1'b0, 1'b0);
    chk("R5 m_en = 5", {32'd0, m_cnten_q}, 64'd5);
  endtask

  task automatic probe(input string req, input logic [1:0] p, input logic [11:0] a, input logic exp);
    priv = p; csr_addr = a;
    #2;
    chk(req, {63'd0, access_ok}, {63'd0, exp});
  endtask

  // m_en = 5 (cycle, instret), s_en = 2 (time)
  task automatic t_access();
    probe("R7 sup C00", 2'd1, 12'hC00, 1'b1);
    probe("R7 sup C01", 2'd1, 12'hC01, 1'b0);
    probe("R7 sup C02", 2'd1, 12'hC02, 1'b1);
    probe("R8 usr C00", 2'd0, 12'hC00, 1'b0);
    probe("R8 usr C01", 2'd0, 12'hC01, 1'b1);
    probe("R8 usr C02", 2'd0, 12'hC02, 1'b0);
    probe("R6 mach C01", 2'd3, 12'hC01, 1'b1);
    probe("R6 prv2 C00", 2'd2, 12'hC00, 1'b1);
    probe("R9 mach C03", 2'd3, 12'hC03, 1'b0);
    probe("R9 usr C1F", 2'd0, 12'hC1F, 1'b0);
    probe("R9 sup C10", 2'd1, 12'hC10, 1'b0);
    probe("R9 C20 pass", 2'd0, 12'hC20, 1'b1);
    probe("R9 BFF pass", 2'd0, 12'hBFF, 1'b1);
    priv = 2'd3; csr_addr = '0;
    step();
  endtask

  task automatic t_instret();
    logic [63:0] i0;
    i0 = instret_q;
    retire = 1'b1; step(); step(); step(); retire = 1'b0;
    chk("R10 retire +3", instret_q, i0 + 64'd3);
    step();
    chk("R10 hold", instret_q, i0 + 64'd3);
    csr_write(12'hB02, 64'd100, 1'b0, 1'b0);
    chk("R11 load", instret_q, 64'd100);
    step(); step();
    chk("R11 idle hold", instret_q, 64'd100);
    retire = 1'b1; step();
    chk("R11 suppressed", instret_q, 64'd100);
    step(); retire = 1'b0;
    chk("R11 resumes", instret_q, 64'd101);
    csr_write(12'hB02, 64'd500, 1'b1, 1'b0);
    chk("R12 same-cycle load", instret_q, 64'd500);
    retire = 1'b1; step();
    chk("R12 next retire swallowed", instret_q, 64'd500);
    step(); retire = 1'b0;
    chk("R12 then counts", instret_q, 64'd501);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_tick();
    t_write_prio();
    t_enables();
    t_access();
    t_instret();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule